// File: doc/BRIEF.md
# Serial ADC Frame Sequencer with Power Management

This block sits on the host side of a single-channel serial sampling converter. It drives the active-low chip select and the serial clock, collects the converter's data line, and turns three high-level commands into correctly shaped frames: take a sample, put the converter to sleep, and wake it up. The commands arrive on a valid/ready handshake. The block returns each sample as a result word with a one-cycle valid strobe, and it reports whether it believes the converter is asleep.

Each frame starts with a new chip-select falling edge. What a frame does depends only on how many serial-clock falling edges pass before chip select is released. A full-length frame carries a conversion. A frame cut short inside the sleep window powers the converter down. A full-length frame whose data is thrown away brings the converter back up. A sample requested while the converter is asleep is preceded automatically by such a dummy wake frame.

The serial clock half-period and the minimum chip-select high time are counted in system-clock cycles and taken from configuration inputs during reset. A floor on the half-period keeps the serial clock at or below the converter's maximum rate.

Top module: `adcseq_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls: `adc_cs_n`=1, `adc_sclk`=1, `cmd_ready`=1, `res_valid`=0, `powered_down`=0. Reset clears `powered_down` even if the converter was put to sleep.
- R2: `cmd_op`=0 (sample) while awake produces one frame with exactly FRAME_CLKS = RES_BITS+4 (16 by default) SCLK falling edges while `adc_cs_n` is low. `adc_sdata` is sampled in the clock cycle in which SCLK is driven low. The bit presented after the CS fall is captured at falling edge 1, and each later bit at the following falling edge. The frame is MSB first, and its last RES_BITS bits appear on `res_data` with a one-cycle `res_valid` pulse as chip select rises.
- R3: `cmd_op`=1 (sleep) produces a frame that releases chip select after exactly PD_CUT (4 by default, inside the open window 2..10) falling edges. It sets `powered_down` to 1 and gives no `res_valid`.
- R4: `cmd_op`=2 (wake) produces a full FRAME_CLKS-edge dummy frame. It clears `powered_down` and gives no `res_valid`, whether or not the converter was asleep.
- R5: `cmd_op`=0 while `powered_down`=1 produces two frames: a full-length dummy frame with no result, then a full-length sample frame with one `res_valid`. `powered_down` ends at 0.
- R6: Between the end of one frame and the start of the next, `adc_cs_n` stays high for at least max(quiet,1) system clocks, where quiet is `cfg_quiet` captured at reset. Between the chained dummy and sample frames of R5 the gap is exactly that value.
- R7: Each SCLK low phase lasts max(`cfg_half_div`, MIN_HALF) system clocks, where `cfg_half_div` is the value captured at reset (MIN_HALF = 5 by default). Changing `cfg_half_div` after reset has no effect.
- R8: `cmd_ready` is low from the cycle after a frame command is accepted until the quiet interval after the last frame of that command has expired, and stays low while chip select is low.
- R9: `cmd_op`=3 is accepted and ignored. No frame starts, `res_valid` stays 0 and `powered_down` keeps its value.
- R10: `adc_sclk` is high whenever `adc_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; also loads configuration |
| cfg_half_div | input | DIV_W | SCLK half-period in system clocks, captured at reset |
| cfg_quiet | input | QUIET_W | Minimum CS high time in system clocks, captured at reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 sample, 1 sleep, 2 wake, 3 no operation |
| cmd_ready | output | 1 | Sequencer can accept a command |
| adc_sdata | input | 1 | Serial data from the converter |
| adc_cs_n | output | 1 | Active-low chip select to the converter |
| adc_sclk | output | 1 | Serial clock to the converter, idles high |
| res_valid | output | 1 | One-cycle strobe for a new result |
| res_data | output | RES_BITS | Last result word |
| powered_down | output | 1 | Believed converter power state, 1 = asleep |

## Verification
A wrong frame kind or edge counter shows up at the chip-select rise: the number of SCLK falling edges in the frame differs from 16 or 4, and `powered_down` or `res_valid` takes the wrong value within the same cycle. A lost chaining flag after a sleep shows up one frame later, as a single frame where two were expected, or as a missing result. A divider or quiet counter loaded with the wrong value shows up within one SCLK phase as a wrong low-phase width, or at the next CS fall as a short high gap. A shift path that is off by one shows up at the first result as a word shifted by one bit.

// File: rtl/adcseq_pkg.sv
`timescale 1ns/1ps
package adcseq_pkg;

    // command codes seen on cmd_op
    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_SLEEP = 2'd1,
        OP_WAKE  = 2'd2,
        OP_NOP   = 2'd3
    } op_e;

    // sequencer phase
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_TAIL,
        ST_QUIET
    } state_e;

    // what the current frame is for
    typedef enum logic [1:0] {
        FR_READ,
        FR_SLEEP,
        FR_WAKE
    } frame_e;

    // frame length in SCLK cycles: four leading bits plus the result
    function automatic int frame_len(input int res_bits);
        return res_bits + 4;
    endfunction

    // falling-edge count at which chip select is released for a frame kind
    function automatic int release_edge(input frame_e kind, input int full_len, input int sleep_cut);
        return (kind == FR_SLEEP) ? sleep_cut : full_len;
    endfunction

endpackage

// File: rtl/adcseq_timer.sv
`timescale 1ns/1ps
module adcseq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt;

    // counts cycles from 1 while run is high; restarts after each expiry
    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= W'(1);
        else if (done)
            cnt <= W'(1);
        else
            cnt <= cnt + W'(1);
    end

    assign done = run && (cnt >= limit);

endmodule

// File: rtl/adcseq_shifter.sv
`timescale 1ns/1ps
module adcseq_shifter #(
    parameter int LEN = 12
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clear,
    input  logic           shift_en,
    input  logic           din,
    output logic [LEN-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst || clear)
            word <= '0;
        else if (shift_en)
            word <= {word[LEN-2:0], din};
    end
endmodule

// File: rtl/adcseq_top.sv
`timescale 1ns/1ps
module adcseq_top
    import adcseq_pkg::*;
#(
    parameter int RES_BITS = 12,
    parameter int DIV_W    = 8,
    parameter int QUIET_W  = 8,
    parameter int MIN_HALF = 5,
    parameter int PD_CUT   = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [DIV_W-1:0]    cfg_half_div,
    input  logic [QUIET_W-1:0]  cfg_quiet,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_op,
    output logic                cmd_ready,
    input  logic                adc_sdata,
    output logic                adc_cs_n,
    output logic                adc_sclk,
    output logic                res_valid,
    output logic [RES_BITS-1:0] res_data,
    output logic                powered_down
);
    localparam int FRAME_CLKS = frame_len(RES_BITS);
    localparam int CNT_W      = $clog2(FRAME_CLKS + 1);

    state_e             state;
    frame_e             kind;
    frame_e             new_kind;
    logic               chain;
    logic [CNT_W-1:0]   falls;
    logic [CNT_W-1:0]   falls_nx;
    logic [CNT_W-1:0]   cut;
    logic [DIV_W-1:0]   half_q;
    logic [QUIET_W-1:0] quiet_q;
    logic               div_tick;
    logic               q_done;
    logic               accept_go;
    logic               chain_go;
    logic               start;
    logic               sample_en;
    logic [RES_BITS-1:0] shift_word;
    op_e                op;

    assign op        = op_e'(cmd_op);
    assign cmd_ready = (state == ST_IDLE);
    assign accept_go = (state == ST_IDLE) && cmd_valid && (op != OP_NOP);
    assign chain_go  = (state == ST_QUIET) && q_done && chain;
    assign start     = accept_go || chain_go;
    assign sample_en = (state == ST_SHIFT) && div_tick && adc_sclk;
    assign falls_nx  = falls + CNT_W'(1);
    assign cut       = CNT_W'(release_edge(kind, FRAME_CLKS, PD_CUT));

    always_comb begin
        if (chain_go)
            new_kind = FR_READ;
        else begin
            unique case (op)
                OP_READ:  new_kind = powered_down ? FR_WAKE : FR_READ;
                OP_SLEEP: new_kind = FR_SLEEP;
                default:  new_kind = FR_WAKE;
            endcase
        end
    end

    adcseq_timer #(.W(DIV_W)) u_div (
        .clk   (clk),
        .rst   (rst),
        .run   ((state == ST_SHIFT) || (state == ST_TAIL)),
        .limit (half_q),
        .done  (div_tick)
    );

    adcseq_timer #(.W(QUIET_W)) u_quiet (
        .clk   (clk),
        .rst   (rst),
        .run   (state == ST_QUIET),
        .limit (quiet_q),
        .done  (q_done)
    );

    adcseq_shifter #(.LEN(RES_BITS)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .clear    (start),
        .shift_en (sample_en),
        .din      (adc_sdata),
        .word     (shift_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            kind         <= FR_READ;
            chain        <= 1'b0;
            falls        <= '0;
            adc_cs_n     <= 1'b1;
            adc_sclk     <= 1'b1;
            res_valid    <= 1'b0;
            res_data     <= '0;
            powered_down <= 1'b0;
            half_q       <= (cfg_half_div < DIV_W'(MIN_HALF)) ? DIV_W'(MIN_HALF) : cfg_half_div;
            quiet_q      <= cfg_quiet;
        end else begin
            res_valid <= 1'b0;
            if (start) begin
                state    <= ST_SHIFT;
                kind     <= new_kind;
                falls    <= '0;
                adc_cs_n <= 1'b0;
                chain    <= accept_go && (op == OP_READ) && powered_down;
            end else begin
                unique case (state)
                    ST_SHIFT: begin
                        if (div_tick) begin
                            adc_sclk <= !adc_sclk;
                            if (adc_sclk) begin
                                falls <= falls_nx;
                                if (falls_nx == cut)
                                    state <= ST_TAIL;
                            end
                        end
                    end
                    ST_TAIL: begin
                        if (div_tick) begin
                            adc_sclk <= 1'b1;
                            adc_cs_n <= 1'b1;
                            state    <= ST_QUIET;
                            unique case (kind)
                                FR_READ: begin
                                    res_valid <= 1'b1;
                                    res_data  <= shift_word;
                                end
                                FR_SLEEP: powered_down <= 1'b1;
                                default:  powered_down <= 1'b0;
                            endcase
                        end
                    end
                    ST_QUIET: begin
                        if (q_done)
                            state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // ---------------- assertion support ----------------
    logic               sclk_d;
    logic [CNT_W-1:0]   chk_falls;
    logic [QUIET_W:0]   hi_cnt;
    logic               seen_frame;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d     <= 1'b1;
            chk_falls  <= '0;
            hi_cnt     <= '0;
            seen_frame <= 1'b0;
        end else begin
            sclk_d <= adc_sclk;
            if (adc_cs_n)
                chk_falls <= '0;
            else if (sclk_d && !adc_sclk)
                chk_falls <= chk_falls + CNT_W'(1);
            if (!adc_cs_n)
                hi_cnt <= '0;
            else if (hi_cnt != '1)
                hi_cnt <= hi_cnt + 1'b1;
            if (!adc_cs_n)
                seen_frame <= 1'b1;
        end
    end

    assert_edge_count_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_cs_n) |-> (chk_falls == CNT_W'(PD_CUT) || chk_falls == CNT_W'(FRAME_CLKS)));

    assert_sclk_idle_R10: assert property (@(posedge clk) disable iff (rst)
        adc_cs_n |-> adc_sclk);

    assert_busy_ready_R8: assert property (@(posedge clk) disable iff (rst)
        !adc_cs_n |-> !cmd_ready);

    assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    assert_quiet_gap_R6: assert property (@(posedge clk) disable iff (rst)
        ($fell(adc_cs_n) && seen_frame) |-> (hi_cnt >= {1'b0, quiet_q}));

    assert_sleep_at_release_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(powered_down) |-> $rose(adc_cs_n));

    assert_no_result_asleep_R4: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> !powered_down);

endmodule

// File: tb/adcseq_test.sv
`timescale 1ns/1ps
module adcseq_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cfg_half = 8'd8;
    logic [7:0]  cfg_quiet = 8'd12;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic        cmd_ready;
    logic        sdata;
    logic        cs_n;
    logic        sclk;
    logic        res_valid;
    logic [11:0] res_data;
    logic        pd;

    always #2.5 clk = ~clk;

    adcseq_top uut (
        .clk          (clk),
        .rst          (rst),
        .cfg_half_div (cfg_half),
        .cfg_quiet    (cfg_quiet),
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_op),
        .cmd_ready    (cmd_ready),
        .adc_sdata    (sdata),
        .adc_cs_n     (cs_n),
        .adc_sclk     (sclk),
        .res_valid    (res_valid),
        .res_data     (res_data),
        .powered_down (pd)
    );

    int checks = 0;
    int errors = 0;

    // converter model and port monitor
    logic [11:0] cur_sample = 12'h000;
    wire  [15:0] frame_word = {4'b0000, cur_sample};
    int   fcount = 0, frames = 0, last_falls = 0, valids = 0;
    int   last_gap = 0, min_gap = 100000, hi_run = 0, seen = 0;
    int   low_run = 0, last_low = 0, idle_bad = 0;
    logic [11:0] last_data = 12'h000;
    logic cs_p = 1'b1, sclk_p = 1'b1;

    assign sdata = (fcount < 16) ? frame_word[15 - fcount] : 1'b0;

    always @(negedge clk) begin
        if (rst) begin
            fcount = 0; hi_run = 0; seen = 0; low_run = 0;
            cs_p = 1'b1; sclk_p = 1'b1;
        end else begin
            if (cs_p && !cs_n) begin
                fcount = 0;
                if (seen != 0) begin
                    last_gap = hi_run;
                    if (hi_run < min_gap) min_gap = hi_run;
                end
                seen = 1;
            end
            if (!cs_n && sclk_p && !sclk) fcount++;
            if (!cs_p && cs_n) begin
                frames++;
                last_falls = fcount;
                hi_run = 0;
            end
            if (cs_n) hi_run++;
            if (!sclk_p && sclk) last_low = low_run;
            if (sclk) low_run = 0; else low_run++;
            if (cs_n && !sclk) idle_bad++;
            if (res_valid) begin valids++; last_data = res_data; end
            cs_p = cs_n;
            sclk_p = sclk;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [7:0] half, input logic [7:0] quiet);
        rst = 1'b1;
        cfg_half = half;
        cfg_quiet = quiet;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic issue(input logic [1:0] op);
        for (int t = 0; t < 5000 && !cmd_ready; t++) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op = op;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (2) @(negedge clk);
        for (int t = 0; t < 5000 && !cmd_ready; t++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // tag[26:24] op[23:22] sample[21:10] frames[9:8] falls[7:3] valids[2:1] pd[0]
    // tag: 0=R2 1=R3 2=R4 3=R5 4=R9
    localparam logic [26:0] VEC [12] = '{
        {3'd0, 2'd0, 12'hA5C, 2'd1, 5'd16, 2'd1, 1'b0},
        {3'd0, 2'd0, 12'h001, 2'd1, 5'd16, 2'd1, 1'b0},
        {3'd1, 2'd1, 12'h7E7, 2'd1, 5'd4,  2'd0, 1'b1},
        {3'd2, 2'd2, 12'h555, 2'd1, 5'd16, 2'd0, 1'b0},
        {3'd0, 2'd0, 12'hFFF, 2'd1, 5'd16, 2'd1, 1'b0},
        {3'd1, 2'd1, 12'h000, 2'd1, 5'd4,  2'd0, 1'b1},
        {3'd3, 2'd0, 12'h3C3, 2'd2, 5'd16, 2'd1, 1'b0},
        {3'd4, 2'd3, 12'h123, 2'd0, 5'd0,  2'd0, 1'b0},
        {3'd1, 2'd1, 12'h0F0, 2'd1, 5'd4,  2'd0, 1'b1},
        {3'd4, 2'd3, 12'h456, 2'd0, 5'd0,  2'd0, 1'b1},
        {3'd3, 2'd0, 12'h800, 2'd2, 5'd16, 2'd1, 1'b0},
        {3'd2, 2'd2, 12'h2AA, 2'd1, 5'd16, 2'd0, 1'b0}
    };

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int f0, v0;
        string tag;

        // R1 reset state
        do_reset(8'd8, 8'd12);
        check("R1 cs_n after reset", int'(cs_n), 1);
        check("R1 sclk after reset", int'(sclk), 1);
        check("R1 ready after reset", int'(cmd_ready), 1);
        check("R1 valid after reset", int'(res_valid), 0);
        check("R1 powered_down after reset", int'(pd), 0);

        // table walk: R2 R3 R4 R5 R9
        for (int i = 0; i < 12; i++) begin
            logic [26:0] v;
            v = VEC[i];
            case (v[26:24])
                3'd0: tag = "R2";
                3'd1: tag = "R3";
                3'd2: tag = "R4";
                3'd3: tag = "R5";
                default: tag = "R9";
            endcase
            cur_sample = v[21:10];
            f0 = frames;
            v0 = valids;
            issue(v[23:22]);
            wait_idle();
            check({tag, " frames"}, frames - f0, int'(v[9:8]));
            if (v[9:8] != 2'd0)
                check({tag, " falling edges"}, last_falls, int'(v[7:3]));
            check({tag, " result strobes"}, valids - v0, int'(v[2:1]));
            if (v[2:1] != 2'd0)
                check({tag, " result word"}, int'(last_data), int'(v[21:10]));
            check({tag, " power state"}, int'(pd), int'(v[0]));
            if (v[26:24] == 3'd3)
                check("R6 chained gap", last_gap, 12);
            if (v[26:24] == 3'd4)
                check("R9 cs_n stays high", int'(cs_n), 1);
        end

        // R6 and R10 over the whole walk, R7 at the configured value
        check("R6 min gap at least quiet", int'(min_gap >= 12), 1);
        check("R10 sclk low while cs high", idle_bad, 0);
        check("R7 sclk low phase", last_low, 8);

        // R8 ready behaviour during and after a frame
        cur_sample = 12'h321;
        issue(2'd0);
        check("R8 ready low after accept", int'(cmd_ready), 0);
        for (int t = 0; t < 5000 && !cs_n; t++) @(negedge clk);
        check("R8 ready low in quiet", int'(cmd_ready), 0);
        wait_idle();
        check("R8 ready high when idle", int'(cmd_ready), 1);
        check("R2 result after R8 frame", int'(last_data), 12'h321);

        // R1 reset clears the sleep state
        issue(2'd1);
        wait_idle();
        check("R3 asleep before reset", int'(pd), 1);
        do_reset(8'd2, 8'd3);
        check("R1 powered_down cleared by reset", int'(pd), 0);
        check("R1 ready after second reset", int'(cmd_ready), 1);

        // R7 clamp to the minimum half period
        cur_sample = 12'hBEE;
        issue(2'd0);
        wait_idle();
        check("R7 clamped low phase", last_low, 5);
        check("R2 result at fast clock", int'(last_data), 12'hBEE);

        // R7 configuration change after reset is ignored
        cfg_half = 8'd20;
        cfg_quiet = 8'd40;
        cur_sample = 12'h0C3;
        issue(2'd0);
        wait_idle();
        check("R7 low phase after cfg change", last_low, 5);

        // R6 back-to-back commands with short quiet
        min_gap = 100000;
        issue(2'd0);
        issue(2'd0);
        wait_idle();
        check("R6 min gap short quiet", int'(min_gap >= 3), 1);
        check("R10 sclk low while cs high at end", idle_bad, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule